// File: doc/BRIEF.md
# Extended-Transfer Register Access Sequencer

The block sits on the host side of an SD I/O link. It takes one register access at a time and carries it out as an extended read/write command (CMD53) on a memory-mapped SD host controller. A request carries a function number, a 17-bit register address, a direction, a width (one byte or a 32-bit word) and a write byte. The block then programs the controller in a fixed order: argument, status clean-up, internal-stop release, block length, block count, command word. After that it polls the controller through a single poll-driven handshake. A read collects its data through the controller's 16-bit data port. Every access ends with a one-cycle `done` pulse that carries a result word and a 2-bit error code.

The controller is reached over a simple register bus. `bus_sel` picks one of eight controller registers. A write is taken in the cycle where `bus_en` and `bus_we` are high. A read is issued in one cycle and its value is on `bus_rdata` in the next cycle. Register selects: 0 command word, 1 argument, 2 stop control, 3 block count, 4 status, 5 error detail, 6 block length, 7 data port.

States:
- `S_IDLE` goes to `S_SET_ARG` when a request arrives.
- The set-up chain runs `S_SET_ARG` → `S_GET_STAT` → `S_CLR_STAT` → `S_GET_STOP` → `S_CLR_STOP` → `S_SET_LEN` → `S_SET_CNT` → `S_ISSUE`.
- The response loop runs `S_POLL_DET` → `S_POLL_RSP` → `S_CHK_RSP`, and returns to `S_POLL_DET` while the response flag is clear.
- The flag loop runs `S_POLL_FLG` ↔ `S_CHK_FLG`.
- From there the path goes to `S_RD_LO` → `S_CAP_LO` (→ `S_CAP_HI`) on a read, or to `S_WR_DATA` on a write.
- The end loop runs `S_POLL_END` ↔ `S_CHK_END`.
- The block then passes through `S_DONE` and returns to `S_IDLE`.
- Any abort jumps straight to `S_DONE`.

Top module: `sdio_xfer_seq`

## Requirements
- R1: For a read, the value written to the argument register (select 1) has bit 31 = 0, the function number in bits 30:28, bit 27 = 0, bit 26 = 1 (incrementing address), the register address in bits 25:9, and the byte count (4 for a word, 1 for a byte) in bits 8:0.
- R2: For a write, argument bit 31 = 1 and bits 8:0 hold 1 whatever the requested width. The write byte is written exactly once to the data port (select 7), zero-extended.
- R3: The command word written to select 0 is 0x5C35 when argument bit 31 is 0 and 0x4C35 when it is 1.
- R4: Before the command, the status register (select 4) is read and written back with bits 31, 25, 24, 22..16, 2 and 0 cleared and all other bits kept. The stop control register (select 2) is read and written back with bit 0 cleared and all other bits kept.
- R5: Before the command, block length (select 6) receives the byte count from bits 8:0 of the argument, and block count (select 3) receives 1.
- R6: While the block waits for the response, each poll reads the error detail register (select 5). If bit 0, bit 2 or bit 8 is set, the access ends with error code 1 and an all-ones result. Other detail bits have no effect.
- R7: If status bit 22 is set when status bit 0 (response end) is first seen, the access ends with error code 2 and an all-ones result.
- R8: After the response, a read waits for status bit 24 and a write waits for status bit 25. The other of these two bits is ignored.
- R9: A word read takes two data-port reads: the first gives result bits 15:0 and the second gives bits 31:16. A byte read returns data-port bits 7:0 with the upper 24 bits zero. A write returns 0.
- R10: After the data phase, the block waits for status bit 2 before it reports completion. Each poll issues exactly one status read, so a successful access reads status exactly once per failed check plus three times.
- R11: One budget of TIMEOUT_INIT failed status checks, shared across the response, flag and end waits, is loaded when the command is issued. The check that uses up the budget ends the access with error code 3 and an all-ones result.
- R12: A request is accepted only in `S_IDLE`. A request raised while the block is busy causes no command and does not change the access in progress.
- R13: After reset the block is idle and issues no bus access. `done` is high for exactly one cycle per access, and error code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_func | input | 3 | Function number |
| req_addr | input | 17 | Register address |
| req_wide | input | 1 | 1 = 32-bit read, 0 = byte |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | High while an access is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Read data, 0 for writes, all ones on error; valid with done |
| err | output | 2 | 0 none, 1 detail error, 2 command timeout, 3 poll budget exhausted |
| bus_en | output | 1 | Controller register access strobe |
| bus_we | output | 1 | 1 = register write |
| bus_sel | output | 4 | Controller register select |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, one cycle after the read |

## Verification
The main sweep runs every direction and width against a controller model. The model raises the response flag, the data-ready flag and the end flag after separate, swept numbers of status polls. Comparing the exact status-read count with the arithmetic prediction shows whether each wait is entered in order and whether polls are skipped or repeated. Some delay sets use up the shared budget, and others stop one check short of it, so the exact point of the software timeout is pinned down. Directed runs set each abort-causing detail bit alone and one harmless detail bit, raise the command-timeout flag, and raise the wrong ready flag for the direction. They also inject a request while the block is busy and use extreme function and address values, so each error code and the per-direction flag choice can be told apart.

// File: rtl/sdio_seq_pkg.sv
package sdio_seq_pkg;

    // Controller register selects
    typedef enum logic [3:0] {
        SEL_CMD    = 4'd0,
        SEL_ARG    = 4'd1,
        SEL_STOP   = 4'd2,
        SEL_BLKCNT = 4'd3,
        SEL_STAT   = 4'd4,
        SEL_ERRDET = 4'd5,
        SEL_BLKLEN = 4'd6,
        SEL_DATA   = 4'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_DETAIL = 2'd1,
        ERR_HW_TMO = 2'd2,
        ERR_SW_TMO = 2'd3
    } err_e;

    typedef enum logic [4:0] {
        S_IDLE, S_SET_ARG, S_GET_STAT, S_CLR_STAT, S_GET_STOP, S_CLR_STOP,
        S_SET_LEN, S_SET_CNT, S_ISSUE, S_POLL_DET, S_POLL_RSP, S_CHK_RSP,
        S_POLL_FLG, S_CHK_FLG, S_RD_LO, S_CAP_LO, S_CAP_HI, S_WR_DATA,
        S_POLL_END, S_CHK_END, S_DONE
    } seq_state_e;

    localparam int FUNC_W = 3;
    localparam int ADDR_W = 17;
    localparam int LEN_W  = 9;
    localparam int PORT_W = 16;

    localparam int BIT_RSP_END  = 0;
    localparam int BIT_DATA_END = 2;
    localparam int BIT_CMD_TMO  = 22;
    localparam int BIT_RX_RDY   = 24;
    localparam int BIT_TX_REQ   = 25;

    localparam logic [31:0] STAT_CLR_MASK  = 32'h837F_0005;
    localparam logic [31:0] DET_ABORT_MASK = 32'h0000_0105;
    localparam logic [15:0] CMDW_READ      = 16'h5C35;
    localparam logic [15:0] CMDW_WRITE     = 16'h4C35;

endpackage

// File: rtl/sdio_arg_build.sv
module sdio_arg_build
    import sdio_seq_pkg::*;
(
    input  logic              wr,
    input  logic [FUNC_W-1:0] fn,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic [31:0]       arg,
    output logic [15:0]       cmd_word,
    output logic [LEN_W-1:0]  xfer_len
);

    always_comb begin
        // writes always move a single byte
        xfer_len = (wide && !wr) ? LEN_W'(4) : LEN_W'(1);
        arg      = {wr, fn, 1'b0, 1'b1, addr, xfer_len};
        cmd_word = arg[31] ? CMDW_WRITE : CMDW_READ;
    end

endmodule

// File: rtl/sdio_poll_timer.sv
module sdio_poll_timer #(
    parameter int INIT = 65536,
    parameter int W    = $clog2(INIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    output logic         expire,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= W'(INIT);
        end else if (dec && count != '0) begin
            count <= count - W'(1);
        end
    end

    // the failing check that would bring the count to zero
    assign expire = dec && (count <= W'(1));

    p_tmr_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == W'(INIT)));

    p_tmr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && count > W'(1)) |=> (count == $past(count) - W'(1)));

endmodule

// File: rtl/sdio_rd_capture.sv
module sdio_rd_capture
    import sdio_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [PORT_W-1:0] port,
    output logic [31:0]       word
);

    logic [PORT_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= port;
            if (cap_hi) hi_q <= port;
        end
    end

    assign word = {hi_q, lo_q};

    p_hi_follows_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hi |-> $past(cap_lo));

    p_no_dual_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_lo && cap_hi));

endmodule

// File: rtl/sdio_xfer_seq.sv
module sdio_xfer_seq
    import sdio_seq_pkg::*;
#(
    parameter int TIMEOUT_INIT = 65536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_func,
    input  logic [16:0] req_addr,
    input  logic        req_wide,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] result,
    output logic [1:0]  err,
    output logic        bus_en,
    output logic        bus_we,
    output logic [3:0]  bus_sel,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata
);

    localparam int TMR_W = $clog2(TIMEOUT_INIT + 1);

    seq_state_e st, nxt;

    logic              wr_q, wide_q;
    logic [FUNC_W-1:0] fn_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wd_q;
    err_e              err_q, err_nxt;
    logic              err_set;

    logic [31:0]       arg;
    logic [15:0]       cmd_word;
    logic [LEN_W-1:0]  xfer_len;
    logic              tmr_load, tmr_dec, tmr_expire;
    logic [TMR_W-1:0]  tmr_count;
    logic              cap_lo, cap_hi;
    logic [31:0]       rd_word;
    logic              accept;
    logic              flag_hit;

    assign accept   = (st == S_IDLE) && req_valid;
    assign flag_hit = wr_q ? bus_rdata[BIT_TX_REQ] : bus_rdata[BIT_RX_RDY];

    sdio_arg_build u_arg (
        .wr       (wr_q),
        .fn       (fn_q),
        .addr     (addr_q),
        .wide     (wide_q),
        .arg      (arg),
        .cmd_word (cmd_word),
        .xfer_len (xfer_len)
    );

    sdio_poll_timer #(.INIT(TIMEOUT_INIT), .W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .dec    (tmr_dec),
        .expire (tmr_expire),
        .count  (tmr_count)
    );

    sdio_rd_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .port   (bus_rdata[PORT_W-1:0]),
        .word   (rd_word)
    );

    // state and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            wr_q   <= 1'b0;
            wide_q <= 1'b0;
            fn_q   <= '0;
            addr_q <= '0;
            wd_q   <= '0;
            err_q  <= ERR_NONE;
        end else begin
            st <= nxt;
            if (accept) begin
                wr_q   <= req_write;
                wide_q <= req_wide & ~req_write;
                fn_q   <= req_func;
                addr_q <= req_addr;
                wd_q   <= req_wdata;
                err_q  <= ERR_NONE;
            end else if (err_set) begin
                err_q  <= err_nxt;
            end
        end
    end

    // next state and bus outputs
    always_comb begin
        nxt       = st;
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_sel   = SEL_CMD;
        bus_wdata = '0;
        tmr_load  = 1'b0;
        tmr_dec   = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        err_set   = 1'b0;
        err_nxt   = ERR_NONE;
        unique case (st)
            S_IDLE: begin
                if (req_valid) nxt = S_SET_ARG;
            end
            S_SET_ARG: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_ARG;
                bus_wdata = arg;
                nxt = S_GET_STAT;
            end
            S_GET_STAT: begin
                bus_en = 1'b1; bus_sel = SEL_STAT;
                nxt = S_CLR_STAT;
            end
            S_CLR_STAT: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_STAT;
                bus_wdata = bus_rdata & ~STAT_CLR_MASK;
                nxt = S_GET_STOP;
            end
            S_GET_STOP: begin
                bus_en = 1'b1; bus_sel = SEL_STOP;
                nxt = S_CLR_STOP;
            end
            S_CLR_STOP: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_STOP;
                bus_wdata = bus_rdata & ~32'h1;
                nxt = S_SET_LEN;
            end
            S_SET_LEN: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_BLKLEN;
                bus_wdata = {{(32-LEN_W){1'b0}}, xfer_len};
                nxt = S_SET_CNT;
            end
            S_SET_CNT: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_BLKCNT;
                bus_wdata = 32'd1;
                nxt = S_ISSUE;
            end
            S_ISSUE: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_CMD;
                bus_wdata = {16'h0, cmd_word};
                tmr_load = 1'b1;
                nxt = S_POLL_DET;
            end
            S_POLL_DET: begin
                bus_en = 1'b1; bus_sel = SEL_ERRDET;
                nxt = S_POLL_RSP;
            end
            S_POLL_RSP: begin
                if ((bus_rdata & DET_ABORT_MASK) != '0) begin
                    err_set = 1'b1; err_nxt = ERR_DETAIL;
                    nxt = S_DONE;
                end else begin
                    bus_en = 1'b1; bus_sel = SEL_STAT;
                    nxt = S_CHK_RSP;
                end
            end
            S_CHK_RSP: begin
                if (bus_rdata[BIT_RSP_END]) begin
                    if (bus_rdata[BIT_CMD_TMO]) begin
                        err_set = 1'b1; err_nxt = ERR_HW_TMO;
                        nxt = S_DONE;
                    end else begin
                        nxt = S_POLL_FLG;
                    end
                end else begin
                    tmr_dec = 1'b1;
                    if (tmr_expire) begin
                        err_set = 1'b1; err_nxt = ERR_SW_TMO;
                        nxt = S_DONE;
                    end else begin
                        nxt = S_POLL_DET;
                    end
                end
            end
            S_POLL_FLG: begin
                bus_en = 1'b1; bus_sel = SEL_STAT;
                nxt = S_CHK_FLG;
            end
            S_CHK_FLG: begin
                if (flag_hit) begin
                    nxt = wr_q ? S_WR_DATA : S_RD_LO;
                end else begin
                    tmr_dec = 1'b1;
                    if (tmr_expire) begin
                        err_set = 1'b1; err_nxt = ERR_SW_TMO;
                        nxt = S_DONE;
                    end else begin
                        nxt = S_POLL_FLG;
                    end
                end
            end
            S_RD_LO: begin
                bus_en = 1'b1; bus_sel = SEL_DATA;
                nxt = S_CAP_LO;
            end
            S_CAP_LO: begin
                cap_lo = 1'b1;
                if (wide_q) begin
                    bus_en = 1'b1; bus_sel = SEL_DATA;
                    nxt = S_CAP_HI;
                end else begin
                    nxt = S_POLL_END;
                end
            end
            S_CAP_HI: begin
                cap_hi = 1'b1;
                nxt = S_POLL_END;
            end
            S_WR_DATA: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_sel = SEL_DATA;
                bus_wdata = {24'h0, wd_q};
                nxt = S_POLL_END;
            end
            S_POLL_END: begin
                bus_en = 1'b1; bus_sel = SEL_STAT;
                nxt = S_CHK_END;
            end
            S_CHK_END: begin
                if (bus_rdata[BIT_DATA_END]) begin
                    nxt = S_DONE;
                end else begin
                    tmr_dec = 1'b1;
                    if (tmr_expire) begin
                        err_set = 1'b1; err_nxt = ERR_SW_TMO;
                        nxt = S_DONE;
                    end else begin
                        nxt = S_POLL_END;
                    end
                end
            end
            S_DONE: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // completion outputs
    always_comb begin
        busy = (st != S_IDLE);
        done = (st == S_DONE);
        err  = err_q;
        if (err_q != ERR_NONE)  result = '1;
        else if (wr_q)          result = '0;
        else if (wide_q)        result = rd_word;
        else                    result = {24'h0, rd_word[7:0]};
    end

    p_cmd_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_sel == SEL_CMD) |->
        (bus_wdata[15:0] == (wr_q ? 16'h4C35 : 16'h5C35)));

    p_blk_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_sel == SEL_BLKCNT) |-> (bus_wdata == 32'd1));

    p_abort_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != 2'd0) |-> (result == 32'hFFFF_FFFF));

    p_end_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err == 2'd0) |-> $past(bus_rdata[2]));

    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(addr_q) && $stable(fn_q) && $stable(wr_q)));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_sdio_xfer_seq.sv
module sim_sdio_xfer_seq;
    import sdio_seq_pkg::*;

    localparam int TO = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_wide;
    logic [2:0]  req_func;
    logic [16:0] req_addr;
    logic [7:0]  req_wdata;
    logic        busy, done, bus_en, bus_we;
    logic [31:0] result, bus_wdata, bus_rdata;
    logic [1:0]  err;
    logic [3:0]  bus_sel;

    always #2 clk = ~clk;

    sdio_xfer_seq #(.TIMEOUT_INIT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_func(req_func), .req_addr(req_addr), .req_wide(req_wide),
        .req_wdata(req_wdata), .busy(busy), .done(done), .result(result),
        .err(err), .bus_en(bus_en), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int vectors = 0, miscompares = 0, cyc = 0;
    bit finished = 0;

    // controller model configuration (set by the stimulus tasks)
    int          m_a, m_b, m_c, m_flagbit;
    logic [31:0] m_det, m_stale, m_stop;
    logic        m_hwto;
    logic [15:0] m_lo, m_hi;

    // controller model state
    logic        m_cmd_seen;
    int          m_n, m_k, m_cmds, m_dwr;
    logic [31:0] l_arg, l_cmd, l_stat, l_stop, l_len, l_cnt, l_data;

    function automatic logic [31:0] stat_word(int n);
        logic [31:0] w = '0;
        if (n >= m_a) begin
            w[0] = 1'b1;
            if (m_hwto) w[22] = 1'b1;
        end
        if (n >= m_b) w[m_flagbit] = 1'b1;
        if (n >= m_c) w[2] = 1'b1;
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd_seen <= 1'b0;
            m_n <= 0; m_k <= 0; m_cmds <= 0; m_dwr <= 0;
            bus_rdata <= '0;
        end else begin
            if (done) m_cmd_seen <= 1'b0;
            if (bus_en && bus_we) begin
                case (bus_sel)
                    SEL_ARG:    l_arg  <= bus_wdata;
                    SEL_STAT:   l_stat <= bus_wdata;
                    SEL_STOP:   l_stop <= bus_wdata;
                    SEL_BLKLEN: l_len  <= bus_wdata;
                    SEL_BLKCNT: l_cnt  <= bus_wdata;
                    SEL_CMD: begin
                        l_cmd <= bus_wdata; m_cmd_seen <= 1'b1;
                        m_n <= 0; m_k <= 0; m_cmds <= m_cmds + 1;
                    end
                    SEL_DATA: begin l_data <= bus_wdata; m_dwr <= m_dwr + 1; end
                    default: ;
                endcase
            end else if (bus_en) begin
                case (bus_sel)
                    SEL_STAT: begin
                        if (!m_cmd_seen) bus_rdata <= m_stale;
                        else begin bus_rdata <= stat_word(m_n); m_n <= m_n + 1; end
                    end
                    SEL_STOP:   bus_rdata <= m_stop;
                    SEL_ERRDET: bus_rdata <= m_cmd_seen ? m_det : 32'h0;
                    SEL_DATA: begin
                        bus_rdata <= (m_k == 0) ? {16'hDEAD, m_lo} : {16'hBEEF, m_hi};
                        m_k <= m_k + 1;
                    end
                    default: bus_rdata <= 32'h0;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    // one access with the model set up beforehand; checks against arithmetic expectations
    task automatic run(input logic wr, input logic wide, input logic [2:0] fn,
                       input logic [16:0] addr, input logic [7:0] wd,
                       input bit swap, input bit inject);
        int exp_err, s, e, cmds0, dwr0, len;
        logic [31:0] exp_arg, exp_res, got_res;
        logic [1:0]  got_err;
        bit seen = 0;
        m_flagbit = (wr ^ swap) ? 25 : 24;
        len = (wr || !wide) ? 1 : 4;
        exp_arg = {wr, fn, 1'b0, 1'b1, addr, 9'(len)};
        s = (m_b > m_a + 1) ? m_b : m_a + 1;
        e = (m_c > s + 1) ? m_c : s + 1;
        if ((m_det & 32'h105) != 0) exp_err = 1;
        else if (m_hwto)            exp_err = 2;
        else if (swap)              exp_err = 3;
        else if (e - 2 >= TO)       exp_err = 3;
        else                        exp_err = 0;
        if (exp_err != 0)  exp_res = 32'hFFFF_FFFF;
        else if (wr)       exp_res = 32'h0;
        else if (wide)     exp_res = {m_hi, m_lo};
        else               exp_res = {24'h0, m_lo[7:0]};
        cmds0 = m_cmds; dwr0 = m_dwr;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_wide = wide; req_func = fn;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 400; i++) begin
            if (inject && i == 4) begin
                req_valid = 1; req_write = ~wr; req_func = ~fn; req_addr = ~addr;
            end else req_valid = 0;
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        req_valid = 0;
        got_res = result; got_err = err;
        chk("R13 done seen", 32'(seen), 32'd1);
        @(negedge clk);
        chk("R13 done one cycle", {31'h0, done}, 32'h0);
        chk(wr ? "R2 argument" : "R1 argument", l_arg, exp_arg);
        chk("R3 command word", l_cmd, wr ? 32'h4C35 : 32'h5C35);
        chk("R4 status clear", l_stat, m_stale & ~32'h837F_0005);
        chk("R4 stop clear", l_stop, m_stop & ~32'h1);
        chk("R5 block length", l_len, 32'(len));
        chk("R5 block count", l_cnt, 32'd1);
        case (exp_err)
            1: chk("R6 error code", 32'(got_err), 32'd1);
            2: chk("R7 error code", 32'(got_err), 32'd2);
            3: chk(swap ? "R8 wrong flag timeout" : "R11 error code", 32'(got_err), 32'd3);
            default: chk("R13 error code", 32'(got_err), 32'd0);
        endcase
        chk(exp_err != 0 ? "R11 result ones" : "R9 result", got_res, exp_res);
        if (exp_err == 0) begin
            chk("R10 status poll count", 32'(m_n), 32'(e + 1));
            chk("R2 data writes", 32'(m_dwr - dwr0), wr ? 32'd1 : 32'd0);
            if (wr) chk("R2 data byte", l_data, {24'h0, wd});
        end
        if (inject) begin
            repeat (3) @(negedge clk);
            chk("R12 single command", 32'(m_cmds - cmds0), 32'd1);
            chk("R12 stays idle", {31'h0, busy}, 32'h0);
        end
    endtask

    task automatic cfg(input int a, input int b, input int c, input logic [31:0] det,
                       input logic hw, input int seed);
        m_a = a; m_b = b; m_c = c; m_det = det; m_hwto = hw;
        m_stale = 32'hA5C3_5A3C ^ (32'(seed) * 32'h0101_1F1F);
        m_stop  = 32'h0000_80D1 ^ (32'(seed) << 4);
        m_lo = 16'h3C00 ^ 16'(seed * 37);
        m_hi = 16'hC300 ^ 16'(seed * 91);
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_wide = 0;
        req_func = '0; req_addr = '0; req_wdata = '0;
        m_a = 0; m_b = 0; m_c = 0; m_flagbit = 24; m_det = 0; m_hwto = 0;
        m_stale = 0; m_stop = 0; m_lo = 0; m_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R13 reset busy", {31'h0, busy}, 32'h0);
        chk("R13 reset done", {31'h0, done}, 32'h0);
        chk("R13 reset bus idle", {31'h0, bus_en}, 32'h0);

        // sweep of flag delays, direction and width
        for (int a = 0; a < 4; a++)
            for (int db = 0; db < 4; db++)
                for (int dc = 0; dc < 4; dc++)
                    for (int m = 0; m < 4; m++) begin
                        int seed = a * 64 + db * 16 + dc * 4 + m;
                        cfg(a, a + db, a + db + dc, 32'h0, 1'b0, seed);
                        run(m[1], m[0], 3'(seed), 17'(seed * 32'h0B3D) ^ 17'h0474,
                            8'(seed * 13), 0, 0);
                    end

        // budget boundary: 5 failed checks pass, 6 fail (R11)
        cfg(5, 6, 7, 32'h0, 1'b0, 3); run(0, 1, 3'd1, 17'h00474, 8'h00, 0, 0);
        cfg(6, 7, 8, 32'h0, 1'b0, 4); run(0, 1, 3'd1, 17'h00474, 8'h00, 0, 0);
        cfg(40, 40, 40, 32'h0, 1'b0, 5); run(1, 0, 3'd2, 17'h0047C, 8'h5A, 0, 0);

        // detail bits (R6): 0, 2, 8 abort; 1 ignored
        cfg(0, 0, 0, 32'h001, 1'b0, 6); run(0, 1, 3'd1, 17'h10000, 8'h00, 0, 0);
        cfg(0, 0, 0, 32'h004, 1'b0, 7); run(1, 0, 3'd1, 17'h10000, 8'h11, 0, 0);
        cfg(0, 0, 0, 32'h100, 1'b0, 8); run(0, 0, 3'd1, 17'h10000, 8'h00, 0, 0);
        cfg(1, 2, 3, 32'h002, 1'b0, 9); run(0, 1, 3'd1, 17'h10000, 8'h00, 0, 0);

        // command timeout flag (R7)
        cfg(1, 1, 1, 32'h0, 1'b1, 10); run(0, 1, 3'd3, 17'h00001, 8'h00, 0, 0);
        cfg(0, 0, 0, 32'h0, 1'b1, 11); run(1, 0, 3'd3, 17'h00001, 8'h77, 0, 0);

        // wrong ready flag for the direction (R8)
        cfg(0, 0, 0, 32'h0, 1'b0, 12); run(0, 1, 3'd1, 17'h00474, 8'h00, 1, 0);
        cfg(0, 0, 0, 32'h0, 1'b0, 13); run(1, 0, 3'd1, 17'h00474, 8'hA5, 1, 0);

        // extreme fields and request while busy (R1, R2, R12)
        cfg(2, 3, 4, 32'h0, 1'b0, 14); run(0, 1, 3'd7, 17'h1FFFF, 8'h00, 0, 1);
        cfg(1, 1, 5, 32'h0, 1'b0, 15); run(1, 1, 3'd7, 17'h1FFFF, 8'hFF, 0, 1);
        cfg(0, 0, 0, 32'h0, 1'b0, 16); run(0, 0, 3'd0, 17'h00000, 8'h00, 0, 0);

        report();
    end

endmodule